// File: doc/BRIEF.md
# PPS-Aligned Machine Time Counter

This block keeps machine time for an accelerator timing generator. A fast reference clock (40 MHz by default) is divided down to a one-millisecond tick. The tick drives a millisecond-within-period counter. One basic period lasts one second, and each period is started by an external one-pulse-per-second (PPS) input. At every PPS rising edge the divider and the millisecond counter are realigned. The period number then advances by one.

Operators start a run by switching the operating mode to the pre-injection value. This clears the period number, so machine time (period number plus millisecond) counts from the start of the run. If the PPS source fails, the counter keeps running on its own and wraps at the end of the period. It also raises a sticky alarm.

Two strobes are derived from the counters:
- a once-per-period snapshot strobe, which tells downstream logic to capture the telegram values;
- a ten-per-period strobe on the 100 ms grid, which paces transmission of the safety flags.

Top module: `mtime_core`

## Requirements
- R1: While `rst_n` is low, all outputs read zero: counters, strobes and the PPS-missing flag.
- R2: `ms_o` increments by one every `CLK_PER_MS` clock cycles and stays within 0 to `MS_PER_PERIOD`-1.
- R3: A rising edge of `pps_i` sets `ms_o` to 0 in the following cycle and restarts the clock divider. The next millisecond step then comes `CLK_PER_MS` cycles after that edge, whatever the phase before. A pulse held high for several cycles counts as one edge.
- R4: With no PPS edge, `ms_o` wraps from `MS_PER_PERIOD`-1 to 0 by itself, and this starts a new period. Such a self-wrap sets `pps_missing_o`, which then stays high until reset. A PPS edge arriving in the same cycle as the wrap does not set it.
- R5: `bpn_o` increases by exactly one at each period start, whether the start comes from a PPS edge or from a self-wrap.
- R6: When `mode_stb_i` is high with `mode_i` equal to `PREINJ_CODE`, `bpn_o` is 0 in the next cycle. Any other code, or that code with the strobe low, leaves `bpn_o` unchanged. A mode change never alters `ms_o`.
- R7: If the pre-injection clear and a period start fall in the same cycle, `bpn_o` becomes 0, not the incremented value.
- R8: `tgm_stb_o` is high for exactly the one cycle in which `ms_o` first reads 0 after a period start, and is low otherwise.
- R9: `safe_stb_o` is high for one cycle whenever `ms_o` takes a new value that is a multiple of `FLAG_MS`, including 0 at a period start.
- R10: `mtime_o` equals `bpn_o` in its upper `BPN_W` bits and `ms_o` in its lower `MS_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_i | input | 1 | Synchronous one-pulse-per-second input; its rising edge is used |
| mode_i | input | MODE_W | Operating mode code |
| mode_stb_i | input | 1 | Qualifies `mode_i` as a new mode for one cycle |
| ms_o | output | MS_W | Millisecond within the current basic period |
| bpn_o | output | BPN_W | Basic-period number since the last pre-injection mode change |
| mtime_o | output | BPN_W+MS_W | Machine time, `{bpn_o, ms_o}` |
| tgm_stb_o | output | 1 | One-cycle strobe at each period start |
| safe_stb_o | output | 1 | One-cycle strobe on every FLAG_MS millisecond boundary |
| pps_missing_o | output | 1 | Sticky flag: the period wrapped without a PPS |

## Verification
The bench aims at the realignment corners:
- **Early PPS.** It lands mid-period, at an odd divider phase. A design that does not restart the divider would take its first millisecond step early.
- **PPS held high for several cycles.** A level-sensitive clear would hold the divider at zero and delay the next step. It could also count extra periods.
- **PPS at the exact natural wrap instant.** A wrong priority between the two period-start causes would raise the missing flag here.
- **Pre-injection mode strobe in the same cycle as a PPS.** Getting this wrong would leave the period number at one instead of zero.
- **Mode-code checks.** A non-matching code, and a matching code without its strobe, must both leave the period number alone.

// File: rtl/mtime_pkg.sv
package mtime_pkg;
    // Default sizing of the machine time counter (40 MHz reference, 1 s period).
    localparam int unsigned MT_CLK_PER_MS_DEF  = 40000;
    localparam int unsigned MT_MS_PER_BP_DEF   = 1000;
    localparam int unsigned MT_FLAG_MS_DEF     = 100;
    localparam int unsigned MT_BPN_W_DEF       = 32;
    localparam int unsigned MT_MODE_W_DEF      = 4;

    // Width helper that never returns zero.
    function automatic int unsigned mt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/mtime_prescaler.sv
module mtime_prescaler
    import mtime_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = MT_CLK_PER_MS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_edge,
    output logic ms_tick
);
    localparam int unsigned DIV_W = mt_width(CLK_PER_MS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_MS - 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ms_tick = 1'b0;
        if (pps_edge) begin
            st_d.div = '0;
        end else if (st_q.div == DIV_LAST) begin
            st_d.div = '0;
            ms_tick  = 1'b1;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the divider phase restarts at the PPS edge
    a_r3_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |=> (st_q.div == '0));

    // R2: no tick is produced in the cycle of a PPS edge
    a_r2_no_tick_on_pps: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |-> !ms_tick);
endmodule

// File: rtl/mtime_ms_ctr.sv
module mtime_ms_ctr
    import mtime_pkg::*;
#(
    parameter int unsigned MS_PER_PERIOD = MT_MS_PER_BP_DEF,
    parameter int unsigned FLAG_MS       = MT_FLAG_MS_DEF,
    localparam int unsigned MS_W         = mt_width(MS_PER_PERIOD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pps_edge,
    input  logic            ms_tick,
    output logic            period_start,
    output logic [MS_W-1:0] ms_o,
    output logic            tgm_stb_o,
    output logic            safe_stb_o,
    output logic            missing_o
);
    localparam int unsigned FL_W = mt_width(FLAG_MS);
    localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_PERIOD - 1);
    localparam logic [FL_W-1:0] FL_LAST = FL_W'(FLAG_MS - 1);

    typedef struct packed {
        logic [MS_W-1:0] ms;
        logic [FL_W-1:0] fl;
        logic            tgm;
        logic            safe;
        logic            miss;
    } ms_st_t;

    ms_st_t st_d, st_q;
    logic   self_wrap;

    always_comb begin
        st_d         = st_q;
        st_d.tgm     = 1'b0;
        st_d.safe    = 1'b0;
        period_start = 1'b0;
        self_wrap    = 1'b0;

        if (pps_edge) begin
            period_start = 1'b1;
        end else if (ms_tick && (st_q.ms == MS_LAST)) begin
            period_start = 1'b1;
            self_wrap    = 1'b1;
        end

        if (period_start) begin
            st_d.ms   = '0;
            st_d.fl   = '0;
            st_d.tgm  = 1'b1;
            st_d.safe = 1'b1;
        end else if (ms_tick) begin
            st_d.ms = st_q.ms + 1'b1;
            if (st_q.fl == FL_LAST) begin
                st_d.fl   = '0;
                st_d.safe = 1'b1;
            end else begin
                st_d.fl = st_q.fl + 1'b1;
            end
        end

        if (self_wrap) st_d.miss = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ms_o       = st_q.ms;
    assign tgm_stb_o  = st_q.tgm;
    assign safe_stb_o = st_q.safe;
    assign missing_o  = st_q.miss;

    // R2: millisecond stays inside the period
    a_r2_ms_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ms <= MS_LAST);

    // R3: PPS edge zeroes the millisecond next cycle
    a_r3_pps_zeroes_ms: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |=> (ms_o == '0));

    // R4: missing flag is sticky
    a_r4_missing_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        missing_o |=> missing_o);

    // R8: snapshot strobe only when the millisecond reads zero
    a_r8_tgm_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tgm_stb_o |-> (ms_o == '0));

    // R9: flag strobe is a single-cycle pulse
    a_r9_safe_single: assert property (@(posedge clk) disable iff (!rst_n)
        safe_stb_o |=> !safe_stb_o);
endmodule

// File: rtl/mtime_period_ctr.sv
module mtime_period_ctr
    import mtime_pkg::*;
#(
    parameter int unsigned BPN_W  = MT_BPN_W_DEF,
    parameter int unsigned MODE_W = MT_MODE_W_DEF,
    parameter logic [MODE_W-1:0] PREINJ_CODE = MODE_W'(1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic              mode_stb,
    input  logic [MODE_W-1:0] mode,
    output logic [BPN_W-1:0]  bpn_o
);
    typedef struct packed {
        logic [BPN_W-1:0] bpn;
    } bp_st_t;

    bp_st_t st_d, st_q;
    logic   run_clear;

    always_comb begin
        st_d      = st_q;
        run_clear = mode_stb && (mode == PREINJ_CODE);
        if (run_clear) begin
            st_d.bpn = '0;
        end else if (period_start) begin
            st_d.bpn = st_q.bpn + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bpn_o = st_q.bpn;

    // R6: a pre-injection mode strobe clears the period number
    a_r6_preinj_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_stb && (mode == PREINJ_CODE)) |=> (bpn_o == '0));

    // R5: a period start without a clear steps by one
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && !(mode_stb && (mode == PREINJ_CODE)))
            |=> (bpn_o == $past(bpn_o) + 1'b1));

    // R7: clear wins over a simultaneous period start
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && mode_stb && (mode == PREINJ_CODE)) |=> (bpn_o == '0));

    // R6: without a start or clear the number holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_start && !mode_stb) |=> $stable(bpn_o));
endmodule

// File: rtl/mtime_core.sv
module mtime_core
    import mtime_pkg::*;
#(
    parameter int unsigned CLK_PER_MS    = MT_CLK_PER_MS_DEF,
    parameter int unsigned MS_PER_PERIOD = MT_MS_PER_BP_DEF,
    parameter int unsigned FLAG_MS       = MT_FLAG_MS_DEF,
    parameter int unsigned BPN_W         = MT_BPN_W_DEF,
    parameter int unsigned MODE_W        = MT_MODE_W_DEF,
    parameter logic [MODE_W-1:0] PREINJ_CODE = MODE_W'(1),
    localparam int unsigned MS_W         = mt_width(MS_PER_PERIOD)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pps_i,
    input  logic [MODE_W-1:0]     mode_i,
    input  logic                  mode_stb_i,
    output logic [MS_W-1:0]       ms_o,
    output logic [BPN_W-1:0]      bpn_o,
    output logic [BPN_W+MS_W-1:0] mtime_o,
    output logic                  tgm_stb_o,
    output logic                  safe_stb_o,
    output logic                  pps_missing_o
);
    typedef struct packed {
        logic pps_prev;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    pps_edge;
    logic    ms_tick;
    logic    period_start;

    always_comb begin
        st_d          = st_q;
        st_d.pps_prev = pps_i;
        pps_edge      = pps_i && !st_q.pps_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mtime_prescaler #(
        .CLK_PER_MS (CLK_PER_MS)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .pps_edge (pps_edge),
        .ms_tick  (ms_tick)
    );

    mtime_ms_ctr #(
        .MS_PER_PERIOD (MS_PER_PERIOD),
        .FLAG_MS       (FLAG_MS)
    ) u_ms (
        .clk          (clk),
        .rst_n        (rst_n),
        .pps_edge     (pps_edge),
        .ms_tick      (ms_tick),
        .period_start (period_start),
        .ms_o         (ms_o),
        .tgm_stb_o    (tgm_stb_o),
        .safe_stb_o   (safe_stb_o),
        .missing_o    (pps_missing_o)
    );

    mtime_period_ctr #(
        .BPN_W       (BPN_W),
        .MODE_W      (MODE_W),
        .PREINJ_CODE (PREINJ_CODE)
    ) u_bp (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_start (period_start),
        .mode_stb     (mode_stb_i),
        .mode         (mode_i),
        .bpn_o        (bpn_o)
    );

    assign mtime_o = {bpn_o, ms_o};

    // R3: a held PPS level produces only one edge
    a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        pps_edge |=> !pps_edge);

    // R8: the snapshot strobe coincides with the flag strobe
    a_r8_tgm_implies_safe: assert property (@(posedge clk) disable iff (!rst_n)
        tgm_stb_o |-> safe_stb_o);
endmodule

// File: tb/mtime_core_tb_top.sv
`timescale 1ns/1ps
module mtime_core_tb_top;
    localparam int unsigned CPM  = 4;
    localparam int unsigned MSP  = 20;
    localparam int unsigned FLG  = 5;
    localparam int unsigned BW   = 32;
    localparam int unsigned MW   = 4;
    localparam int unsigned MSW  = 5;
    localparam logic [MW-1:0] PRE   = 4'd3;
    localparam logic [MW-1:0] OTHER = 4'd5;

    localparam logic [2:0] K_NONE = 3'd0;
    localparam logic [2:0] K_PPS  = 3'd1;
    localparam logic [2:0] K_MPRE = 3'd2;
    localparam logic [2:0] K_MOTH = 3'd3;
    localparam logic [2:0] K_BOTH = 3'd4;

    // {idle cycles, event, exp ms, exp bpn, exp missing, exp tgm, exp safe}
    localparam int NV = 13;
    localparam logic [29:0] VEC [NV] = '{
        {8'd2,  K_NONE, 8'd0,  8'd0, 3'b000}, // R2 phase 3, no step yet
        {8'd0,  K_NONE, 8'd1,  8'd0, 3'b000}, // R2 first step after 4 clocks
        {8'd15, K_NONE, 8'd5,  8'd0, 3'b001}, // R9 grid strobe at ms 5
        {8'd0,  K_NONE, 8'd5,  8'd0, 3'b000}, // R9 strobe lasts one cycle
        {8'd9,  K_PPS,  8'd0,  8'd1, 3'b011}, // R3 early PPS at odd phase
        {8'd0,  K_NONE, 8'd0,  8'd1, 3'b000}, // R8 strobe drops
        {8'd78, K_PPS,  8'd0,  8'd2, 3'b011}, // R4 PPS on wrap instant, no alarm
        {8'd6,  K_MOTH, 8'd1,  8'd2, 3'b000}, // R6 other mode code ignored
        {8'd0,  K_MPRE, 8'd2,  8'd0, 3'b000}, // R6 pre-injection clear, ms kept
        {8'd71, K_NONE, 8'd0,  8'd1, 3'b111}, // R4 self wrap raises alarm, R5
        {8'd3,  K_PPS,  8'd0,  8'd2, 3'b111}, // R4 alarm sticky, R5
        {8'd39, K_BOTH, 8'd0,  8'd0, 3'b111}, // R7 clear beats PPS increment
        {8'd42, K_NONE, 8'd10, 8'd0, 3'b100}  // R2 mid-period, no strobe
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pps_i = 1'b0;
    logic [MW-1:0]  mode_i = '0;
    logic           mode_stb_i = 1'b0;
    logic [MSW-1:0] ms_o;
    logic [BW-1:0]  bpn_o;
    logic [BW+MSW-1:0] mtime_o;
    logic           tgm_stb_o, safe_stb_o, pps_missing_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mtime_core #(
        .CLK_PER_MS(CPM), .MS_PER_PERIOD(MSP), .FLAG_MS(FLG),
        .BPN_W(BW), .MODE_W(MW), .PREINJ_CODE(PRE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pps_i(pps_i), .mode_i(mode_i),
        .mode_stb_i(mode_stb_i), .ms_o(ms_o), .bpn_o(bpn_o), .mtime_o(mtime_o),
        .tgm_stb_o(tgm_stb_o), .safe_stb_o(safe_stb_o), .pps_missing_o(pps_missing_o)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input int ems, input int ebpn, input bit emiss,
                             input bit etgm, input bit esafe);
        logic [BW+MSW-1:0] emt;
        emt = {BW'(ebpn), MSW'(ems)};
        check("R2", "ms",      64'(ms_o),          64'(ems));
        check("R5", "bpn",     64'(bpn_o),         64'(ebpn));
        check("R4", "missing", 64'(pps_missing_o), 64'(emiss));
        check("R8", "tgm",     64'(tgm_stb_o),     64'(etgm));
        check("R9", "safe",    64'(safe_stb_o),    64'(esafe));
        check("R10", "mtime",  64'(mtime_o),       64'(emt));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_all(0, 0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [2:0] k;
            k = VEC[i][21:19];
            repeat (int'(VEC[i][29:22])) @(negedge clk);
            pps_i      = (k == K_PPS) || (k == K_BOTH);
            mode_stb_i = (k == K_MPRE) || (k == K_MOTH) || (k == K_BOTH);
            mode_i     = (k == K_MOTH) ? OTHER : PRE;
            @(negedge clk);
            check_all(int'(VEC[i][18:11]), int'(VEC[i][10:3]),
                      VEC[i][2], VEC[i][1], VEC[i][0]);
            pps_i = 1'b0; mode_stb_i = 1'b0; mode_i = '0;
        end

        // R5: PPS advances the period number from zero
        pps_i = 1'b1;
        @(negedge clk);
        check("R5", "bpn after pps", 64'(bpn_o), 64'd1);
        pps_i = 1'b0;

        // R6: pre-injection code without its strobe is ignored
        mode_i = PRE;
        @(negedge clk);
        check("R6", "bpn no strobe", 64'(bpn_o), 64'd1);
        mode_i = '0;

        // R3: PPS held high for three cycles counts once
        pps_i = 1'b1;
        @(negedge clk);
        check("R3", "bpn held edge", 64'(bpn_o), 64'd2);
        check("R3", "ms held edge",  64'(ms_o),  64'd0);
        @(negedge clk);
        check("R8", "tgm held",      64'(tgm_stb_o), 64'd0);
        @(negedge clk);
        check("R3", "bpn held 3",    64'(bpn_o), 64'd2);
        pps_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R3", "ms step 4 after edge", 64'(ms_o), 64'd1);

        // R1: asynchronous reset mid-run clears the sticky alarm too
        rst_n = 1'b0;
        #1;
        check("R1", "ms reset",      64'(ms_o),          64'd0);
        check("R1", "bpn reset",     64'(bpn_o),         64'd0);
        check("R1", "missing reset", 64'(pps_missing_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule